// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block watches an active-low composite sync logic signal that has already been sliced from video. It measures how long each low pulse lasts and sorts it into one of three kinds: a short equalising pulse, a normal line sync pulse, or a broad field pulse. From that it produces an active-low vertical sync pulse and a flag that marks odd and even fields. All timing is given as clock-cycle counts through parameters, so one netlist can serve any line standard and any sample clock.

Vertical sync starts when a broad pulse ends. That edge is where the first serration begins. Equalising pulses and line sync pulses cannot start it. Some sources send one long low pulse with no serrations. For those, vertical sync starts on its own once the low level has lasted a fixed number of cycles. The pulse stays low until the second equalising pulse after the broad group, with a hard upper limit on its length. The field flag is set when vertical sync starts. It is decided by how far the first field pulse lies from the last line sync: about a full line, or about half a line.

Top module: `vsync_field_detector`

## Requirements
- R1: While rst_n is low, vsync_n is 1 and odd_field is 0.
- R2: csync_n is sampled on every rising clock edge. A pulse width W is the number of consecutive low samples. If a pulse with BROAD_MIN <= W < DEFAULT_DLY ends while the detector is armed, vsync_n goes low at the clock edge after the edge that first samples csync_n high again.
- R3: A pulse with W <= EQ_MAX is an equalising pulse. A pulse with EQ_MAX < W < BROAD_MIN is a line sync pulse. Neither kind ever starts vertical sync.
- R4: If csync_n is sampled low on DEFAULT_DLY consecutive edges while the detector is armed, vsync_n goes low at the next edge, without waiting for the pulse to end.
- R5: While vsync_n is low, it returns high at the edge after the end of the second equalising pulse counted since vertical sync started or since the latest broad pulse ended, whichever is later. The end of a broad pulse clears the count. Line sync pulses neither count nor end vertical sync.
- R6: vsync_n is never low for more than VS_MAX consecutive cycles. After VS_MAX low cycles it returns high.
- R7: The detector is armed after reset. It disarms when vertical sync starts. It re-arms only when a line sync pulse ends while vsync_n is high. Broad or long pulses seen while disarmed have no effect on vsync_n.
- R8: When vertical sync starts, odd_field becomes 1 if G >= ODD_SPLIT and 0 otherwise. G is the number of clock edges from the first low sample of the latest line sync pulse to the first low sample of the pulse that starts vertical sync. G saturates at 2^CNT_W-1, and takes that value when no line sync pulse has been seen since reset.
- R9: odd_field changes only on the clock edge at which vsync_n falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csync_n | input | 1 | Composite sync logic level, low during sync pulses, synchronous to clk |
| vsync_n | output | 1 | Vertical sync, active low |
| odd_field | output | 1 | 1 during odd fields, 0 during even fields |

## Verification
The bench uses a scaled-down timing set: EQ_MAX=6, BROAD_MIN=20, DEFAULT_DLY=40, ODD_SPLIT=48, VS_MAX=300 and CNT_W=10, with a 64-cycle line. A whole field, the no-serration fallback and the length limit each fit in a few hundred cycles. Every class boundary (widths 6/7, 19/20 and 39/40), the half-line and full-line spacing either side of ODD_SPLIT, and the case where no equalising pulse arrives can all be reached many times over. Random pulse trains across all four width ranges then drive the disarm and re-arm sequence into orders that the directed fields do not produce.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

  typedef enum logic [1:0] {
    PK_EQ    = 2'd0,
    PK_LINE  = 2'd1,
    PK_BROAD = 2'd2
  } pulse_kind_t;

  // Width thresholds: at or below eq_max is equalising, from broad_min up is broad.
  function automatic pulse_kind_t kind_of_width(input logic [31:0] w,
                                                input logic [31:0] eq_max,
                                                input logic [31:0] broad_min);
    if (w >= broad_min) return PK_BROAD;
    if (w > eq_max) return PK_LINE;
    return PK_EQ;
  endfunction

  // A full-line lead (not a half-line one) marks an odd field.
  function automatic logic gap_is_full_line(input logic [31:0] gap,
                                            input logic [31:0] split);
    return gap >= split;
  endfunction

endpackage

// File: rtl/vfd_edge_meter.sv
module vfd_edge_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csync_n,
  output logic             lvl_q,
  output logic             fall,
  output logic             rise,
  output logic [CNT_W-1:0] run_len,
  output logic [CNT_W-1:0] width
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic lvl_d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b1;
      lvl_d1 <= 1'b1;
    end else begin
      lvl_q  <= csync_n;
      lvl_d1 <= lvl_q;
    end
  end

  assign fall = lvl_d1 & ~lvl_q;
  assign rise = ~lvl_d1 & lvl_q;

  // Low samples in the current run, including this one.
  always_comb begin
    if (fall)               run_len = {{(CNT_W-1){1'b0}}, 1'b1};
    else if (width == MAXV) run_len = width;
    else                    run_len = width + 1'b1;
  end

  // Holds the finished pulse width through the high interval.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      width <= '0;
    else if (!lvl_q) width <= run_len;
  end

endmodule

// File: rtl/vfd_pulse_classifier.sv
module vfd_pulse_classifier
  import vfd_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int EQ_MAX      = 80,
  parameter int BROAD_MIN   = 324,
  parameter int DEFAULT_DLY = 1015
) (
  input  logic             lvl_q,
  input  logic             rise,
  input  logic [CNT_W-1:0] run_len,
  input  logic [CNT_W-1:0] width,
  output logic             eq_end,
  output logic             line_end,
  output logic             broad_end,
  output logic             long_hit
);
  localparam logic [CNT_W-1:0] DLY_C = CNT_W'(DEFAULT_DLY);

  pulse_kind_t kind;

  always_comb kind = kind_of_width(32'(width), 32'(EQ_MAX), 32'(BROAD_MIN));

  assign eq_end    = rise && (kind == PK_EQ);
  assign line_end  = rise && (kind == PK_LINE);
  assign broad_end = rise && (kind == PK_BROAD);
  assign long_hit  = ~lvl_q && (run_len == DLY_C);

endmodule

// File: rtl/vfd_gap_tracker.sv
module vfd_gap_tracker #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  input  logic             line_end,
  input  logic [CNT_W-1:0] width,
  output logic [CNT_W-1:0] lead_gap
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] since_line;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == MAXV) ? v : v + 1'b1;
  endfunction

  // since_line: edges elapsed since the latest line sync pulse went low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_line <= MAXV;
      lead_gap   <= MAXV;
    end else begin
      if (line_end) since_line <= sat_inc(width);
      else          since_line <= sat_inc(since_line);
      if (fall)     lead_gap   <= since_line;
    end
  end

endmodule

// File: rtl/vfd_vsync_ctrl.sv
module vfd_vsync_ctrl
  import vfd_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int ODD_SPLIT = 1296,
  parameter int VS_MAX    = 5184
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             broad_end,
  input  logic             eq_end,
  input  logic             line_end,
  input  logic             long_hit,
  input  logic [CNT_W-1:0] lead_gap,
  output logic             vsync_n,
  output logic             odd_field,
  output logic             ev_start,
  output logic             ev_stop,
  output logic             ev_timeout
);
  localparam int TMR_W = (VS_MAX > 2) ? $clog2(VS_MAX) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(VS_MAX - 1);

  logic             active;
  logic             armed;
  logic             eq_once;
  logic [TMR_W-1:0] timer;

  assign ev_start   = armed & (broad_end | long_hit);
  assign ev_timeout = active && (timer == TMR_LAST);
  assign ev_stop    = active & (ev_timeout | (eq_end & eq_once));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      armed     <= 1'b1;
      eq_once   <= 1'b0;
      timer     <= '0;
      odd_field <= 1'b0;
    end else if (ev_start) begin
      active    <= 1'b1;
      armed     <= 1'b0;
      eq_once   <= 1'b0;
      timer     <= '0;
      odd_field <= gap_is_full_line(32'(lead_gap), 32'(ODD_SPLIT));
    end else if (ev_stop) begin
      active    <= 1'b0;
    end else if (active) begin
      timer <= timer + 1'b1;
      if (broad_end)   eq_once <= 1'b0;
      else if (eq_end) eq_once <= 1'b1;
    end else if (line_end) begin
      armed <= 1'b1;
    end
  end

  assign vsync_n = ~active;

endmodule

// File: rtl/vsync_field_detector.sv
module vsync_field_detector #(
  parameter int CNT_W       = 16,
  parameter int EQ_MAX      = 80,
  parameter int BROAD_MIN   = 324,
  parameter int DEFAULT_DLY = 1015,
  parameter int ODD_SPLIT   = 1296,
  parameter int VS_MAX      = 5184
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n,
  output logic vsync_n,
  output logic odd_field
);
  logic             lvl_q;
  logic             fall;
  logic             rise;
  logic [CNT_W-1:0] run_len;
  logic [CNT_W-1:0] width;
  logic             eq_end;
  logic             line_end;
  logic             broad_end;
  logic             long_hit;
  logic [CNT_W-1:0] lead_gap;
  logic             ev_start;
  logic             ev_stop;
  logic             ev_timeout;

  vfd_edge_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n),
    .lvl_q(lvl_q), .fall(fall), .rise(rise),
    .run_len(run_len), .width(width)
  );

  vfd_pulse_classifier #(
    .CNT_W(CNT_W), .EQ_MAX(EQ_MAX), .BROAD_MIN(BROAD_MIN), .DEFAULT_DLY(DEFAULT_DLY)
  ) u_class (
    .lvl_q(lvl_q), .rise(rise), .run_len(run_len), .width(width),
    .eq_end(eq_end), .line_end(line_end), .broad_end(broad_end), .long_hit(long_hit)
  );

  vfd_gap_tracker #(.CNT_W(CNT_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .fall(fall), .line_end(line_end),
    .width(width), .lead_gap(lead_gap)
  );

  vfd_vsync_ctrl #(
    .CNT_W(CNT_W), .ODD_SPLIT(ODD_SPLIT), .VS_MAX(VS_MAX)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .broad_end(broad_end), .eq_end(eq_end), .line_end(line_end), .long_hit(long_hit),
    .lead_gap(lead_gap),
    .vsync_n(vsync_n), .odd_field(odd_field),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_timeout(ev_timeout)
  );

endmodule

// File: rtl/vfd_checker.sv
module vfd_checker #(
  parameter int VS_MAX = 5184
) (
  input logic clk,
  input logic rst_n,
  input logic vsync_n,
  input logic odd_field,
  input logic ev_start,
  input logic ev_stop,
  input logic ev_timeout,
  input logic broad_end,
  input logic eq_end,
  input logic line_end
);
  localparam int LR_W = $clog2(VS_MAX + 2);

  logic [LR_W-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run <= '0;
    else if (!vsync_n) low_run <= low_run + 1'b1;
    else               low_run <= '0;
  end

  // R2 and R4: a falling vsync_n always follows a start event
  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> $past(ev_start));

  assert_no_start_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_n && (eq_end || line_end)) |=> vsync_n);

  assert_stop_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> $past(ev_stop));

  assert_max_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= LR_W'(VS_MAX));

  assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync_n && broad_end && !ev_timeout) |=> !vsync_n);

  assert_odd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(vsync_n) |-> $stable(odd_field));

endmodule

bind vsync_field_detector vfd_checker #(.VS_MAX(VS_MAX)) u_vfd_chk (
  .clk(clk), .rst_n(rst_n), .vsync_n(vsync_n), .odd_field(odd_field),
  .ev_start(ev_start), .ev_stop(ev_stop), .ev_timeout(ev_timeout),
  .broad_end(broad_end), .eq_end(eq_end), .line_end(line_end)
);

// File: tb/sim_vsync_field_detector.sv
`timescale 1ns/1ps
module sim_vsync_field_detector;
  localparam int CW   = 10;
  localparam int EQM  = 6;
  localparam int BRM  = 20;
  localparam int DLY  = 40;
  localparam int SPL  = 48;
  localparam int VSM  = 300;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync_n = 1'b1;
  logic vsync_n, odd_field;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vsync_field_detector #(
    .CNT_W(CW), .EQ_MAX(EQM), .BROAD_MIN(BRM), .DEFAULT_DLY(DLY),
    .ODD_SPLIT(SPL), .VS_MAX(VSM)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n),
    .vsync_n(vsync_n), .odd_field(odd_field)
  );

  task automatic check_bit(input string tag, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b time=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference: 0 equalising, 1 line sync, 2 broad
  function automatic int width_class(input int w);
    if (w >= BRM) return 2;
    if (w <= EQM) return 0;
    return 1;
  endfunction

  function automatic bit expect_odd(input bit seen, input int at_fall, input int at_line);
    int g;
    g = seen ? at_fall - at_line : MAXV;
    if (g > MAXV) g = MAXV;
    return g >= SPL;
  endfunction

  bit exp_vs = 1'b1, exp_odd = 1'b0, nxt_vs = 1'b1, nxt_odd = 1'b0;
  bit m_prev = 1'b1, m_armed = 1'b1, m_eq = 1'b0, have_line = 1'b0;
  int run = 0, low_len = 0, tnow = 0, fall_t = 0, line_t = 0;
  string vs_tag = "R1", odd_tag = "R1", nvs_tag = "R1", nodd_tag = "R1";

  always @(posedge clk) begin
    bit s, fl, rs;
    int cls;
    if (!rst_n) begin
      exp_vs = 1'b1; exp_odd = 1'b0; nxt_vs = 1'b1; nxt_odd = 1'b0;
      m_prev = 1'b1; m_armed = 1'b1; m_eq = 1'b0; have_line = 1'b0;
      run = 0; low_len = 0; tnow = 0;
      vs_tag = "R1"; odd_tag = "R1"; nvs_tag = "R1"; nodd_tag = "R1";
    end else begin
      exp_vs = nxt_vs; exp_odd = nxt_odd; vs_tag = nvs_tag; odd_tag = nodd_tag;
      low_len = exp_vs ? 0 : low_len + 1;
      tnow++;
      s  = csync_n;
      fl = !s && m_prev;
      rs = s && !m_prev;
      if (!s) begin
        if (fl) begin run = 1; fall_t = tnow; end
        else run++;
      end
      cls = width_class(run);
      nodd_tag = "R9";
      if (m_armed && ((rs && cls == 2) || (!s && run == DLY))) begin
        nxt_vs = 1'b0;
        nvs_tag = rs ? "R2" : "R4";
        nxt_odd = expect_odd(have_line, fall_t, line_t);
        nodd_tag = "R8";
        m_armed = 1'b0;
        m_eq = 1'b0;
      end else if (!exp_vs) begin
        if (low_len == VSM) begin
          nxt_vs = 1'b1; nvs_tag = "R6";
        end else if (rs && cls == 0 && m_eq) begin
          nxt_vs = 1'b1; nvs_tag = "R5";
        end else if (rs && cls == 2) begin
          m_eq = 1'b0; nvs_tag = "R7";
        end else if (rs && cls == 0) begin
          m_eq = 1'b1; nvs_tag = "R5";
        end
      end else if (rs) begin
        if (cls == 1) m_armed = 1'b1;
        nvs_tag = (cls == 2) ? "R7" : "R3";
      end
      if (rs && cls == 1) begin line_t = fall_t; have_line = 1'b1; end
      m_prev = s;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check_bit(vs_tag, "vsync_n", vsync_n, exp_vs);
      check_bit(odd_tag, "odd_field", odd_field, exp_odd);
    end
  end

  task automatic hold(input bit lvl, input int n);
    csync_n = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int lw, input int hw);
    hold(1'b0, lw);
    hold(1'b1, hw);
  endtask

  task automatic lines(input int n);
    repeat (n) pulse(10, 54);
  endtask

  task automatic field(input int pre_eq, input bit full_lead);
    lines(3);
    pulse(10, full_lead ? 54 : 22);
    repeat (pre_eq) pulse(4, 28);
    repeat (5) pulse(28, 4);
    repeat (5) pulse(4, 28);
    lines(3);
  endtask

  initial begin
    void'($urandom(32'd9157));
    repeat (3) @(negedge clk);
    check_bit("R1", "vsync_n under reset", vsync_n, 1'b1);
    check_bit("R1", "odd_field under reset", odd_field, 1'b0);
    rst_n = 1'b1;
    lines(4);
    // R2 and R8: full-line lead gives odd, half-line gives even
    field(0, 1'b1);
    field(0, 1'b0);
    field(3, 1'b1);
    field(0, 1'b0);
    // R4: single long pulse without serrations
    lines(3); pulse(10, 54); pulse(60, 4); repeat (4) pulse(4, 28); lines(3);
    lines(3); pulse(10, 22); pulse(60, 4); repeat (4) pulse(4, 28); lines(3);
    // R6: broad group with no equalising pulses after it
    lines(3); repeat (5) pulse(28, 4); lines(8);
    // R3 boundaries: width 19 and 6 must not start
    lines(2); pulse(19, 40); pulse(6, 26); pulse(7, 26); lines(2);
    // R2 lower boundary, then R5: width-7 pulse is not counted
    pulse(20, 12); pulse(7, 26); pulse(6, 26); pulse(6, 26); lines(3);
    // R2 upper boundary and R4 exact threshold
    pulse(39, 4); pulse(4, 28); pulse(4, 28); lines(3);
    pulse(40, 4); pulse(4, 28); pulse(4, 28); lines(3);
    // R7: broad pulses after the end but before a line sync stay ignored
    pulse(28, 4); pulse(4, 28); pulse(4, 28); pulse(28, 4); pulse(45, 10); lines(3);
    for (int i = 0; i < 400; i++) begin
      int k, lw, hw;
      k = $urandom % 6;
      case (k)
        0: lw = 1 + $urandom % EQM;
        1: lw = EQM + 1 + $urandom % (BRM - EQM - 1);
        2: lw = 10;
        3: lw = BRM + $urandom % (DLY - BRM);
        4: lw = DLY + $urandom % 30;
        default: lw = 4;
      endcase
      hw = 2 + $urandom % 69;
      pulse(lw, hw);
      if ($urandom % 40 == 0) field($urandom % 3, $urandom % 2);
    end
    lines(6);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=running expected=finished time=%0t", $time);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule